// File: doc/BRIEF.md
# Late-Binding Register Renamer

This block renames registers in two steps for an out-of-order core. When an instruction is decoded, its destination gets a dependence tag taken from a free pool. Its sources are translated through a logical-to-tag table. Each source comes back with a flag that shows whether a storage register already holds its value. A storage register is taken from a second free pool only when the result is written back. From then on, a tag-to-storage table records which storage register the tag is bound to.

Storage registers are scarce, so a few of them are held back for the oldest in-flight instructions. The age of a write-back is its reorder-buffer distance from the head, where 0 is the oldest instruction. Younger write-backs that find only held-back registers, and any write-back that finds none at all, are told to re-execute later. When an instruction commits, the core hands back the tag that its destination previously held. That tag returns to its pool. If the tag was bound, its storage register returns to the storage pool as well. Each cycle the block accepts one rename, one write-back and one commit.

Top module: `vp_renamer`

## Requirements
- R1: After reset, logical register i maps to tag i, tag i is bound to storage register i, and every output is 0. Free tags are NLOG..NVP-1 and free storage registers are NLOG..NPHYS-1, each pool in ascending order.
- R2: An accepted rename drives `rn_valid_o` one cycle after the request. In that cycle `rn_dst_vp_o` is the oldest free tag (first-in, first-out) and `rn_prev_vp_o` is the tag the destination held before the rename.
- R3: Source lookups use the table as it stood before the same request's own update. A source equal to that request's destination therefore returns the old tag.
- R4: A newly renamed tag reports as unbound (`bound` = 0) until a write-back binds it. After that it reports as bound (`bound` = 1).
- R5: A granted write-back raises `wb_done_o` one cycle later. `wb_preg_o` carries the oldest free storage register.
- R6: When the number of free storage registers is at most NRR, only a write-back with age below NRR is granted. Any other write-back raises `wb_reexec_o`, and `wb_preg_o` reads 0.
- R7: When no storage register is free, every write-back raises `wb_reexec_o`, whatever its age.
- R8: A commit returns its previous tag to the tail of the tag pool. If that tag was bound, its storage register returns to the tail of the storage pool.
- R9: A rename request with no free tag raises `rn_stall_o` one cycle later, with `rn_valid_o` at 0, and leaves the logical table unchanged.
- R10: `wb_done_o` and `wb_reexec_o` are never high together, and neither are `rn_valid_o` and `rn_stall_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ren_valid_i | input | 1 | Rename request |
| ren_dst_i | input | 5 | Logical destination |
| ren_src1_i | input | 5 | Logical source 1 |
| ren_src2_i | input | 5 | Logical source 2 |
| rn_valid_o | output | 1 | Rename accepted |
| rn_stall_o | output | 1 | Rename refused, no tag free |
| rn_src1_vp_o | output | 6 | Tag of source 1 |
| rn_src1_bound_o | output | 1 | Source 1 tag has a storage register |
| rn_src2_vp_o | output | 6 | Tag of source 2 |
| rn_src2_bound_o | output | 1 | Source 2 tag has a storage register |
| rn_dst_vp_o | output | 6 | New destination tag |
| rn_prev_vp_o | output | 6 | Tag the destination held before |
| wb_valid_i | input | 1 | Write-back allocation request |
| wb_vp_i | input | 6 | Tag being written back |
| wb_age_i | input | 6 | Reorder-buffer distance from head (0 = oldest) |
| wb_done_o | output | 1 | Storage register granted |
| wb_reexec_o | output | 1 | Not granted, re-execute later |
| wb_preg_o | output | 6 | Granted storage register |
| cm_valid_i | input | 1 | Commit release |
| cm_prev_vp_i | input | 6 | Previous tag of committing destination |

## Verification
Four properties are checked on every cycle by assertions:
- the two outcome pairs never overlap;
- a grant happened either with more than NRR registers free or for an instruction among the NRR oldest;
- a re-execute happened only when NRR or fewer registers were free;
- a stall happened only when the tag pool was empty.

The directed scenarios check the things that depend on sequence. These include the first-in, first-out order of both pools and the reuse of released registers at the tail. They also include a source reading the old tag of its own destination, the change of the bound flag from 0 to 1, and a stalled rename leaving the logical table untouched.

// File: rtl/rnm_pkg.sv
package rnm_pkg;
  typedef enum logic [1:0] {
    WB_IDLE   = 2'd0,
    WB_GRANT  = 2'd1,
    WB_REEXEC = 2'd2
  } wb_result_e;
endpackage

// File: rtl/rnm_free_fifo.sv
module rnm_free_fifo #(
  parameter int DEPTH      = 64,
  parameter int W          = 6,
  parameter int INIT_BASE  = 32,
  parameter int INIT_COUNT = 32,
  localparam int PTRW = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_i,
  input  logic [W-1:0]  push_data_i,
  input  logic          pop_i,
  output logic [W-1:0]  head_o,
  output logic [CW-1:0] count_o
);
  logic [W-1:0]    mem [DEPTH];
  logic [PTRW-1:0] rd_ptr, wr_ptr;

  function automatic logic [PTRW-1:0] bump(input logic [PTRW-1:0] p);
    return (p == PTRW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign head_o = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++)
        mem[i] <= (i < INIT_COUNT) ? W'(INIT_BASE + i) : '0;
      rd_ptr  <= '0;
      wr_ptr  <= PTRW'(INIT_COUNT % DEPTH);
      count_o <= CW'(INIT_COUNT);
    end else begin
      if (push_i) begin
        mem[wr_ptr] <= push_data_i;
        wr_ptr      <= bump(wr_ptr);
      end
      if (pop_i) rd_ptr <= bump(rd_ptr);
      count_o <= count_o + CW'(push_i) - CW'(pop_i);
    end
  end

  AST_FIFO_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (push_i && !pop_i) |-> (count_o < CW'(DEPTH))); // R8
  AST_FIFO_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    pop_i |-> (count_o != '0)); // R9
endmodule

// File: rtl/rnm_wb_alloc.sv
module rnm_wb_alloc
  import rnm_pkg::*;
#(
  parameter int NRR = 4,
  parameter int CW  = 6,
  parameter int AW  = 6
) (
  input  logic          req_i,
  input  logic [CW-1:0] free_cnt_i,
  input  logic [AW-1:0] age_i,
  output wb_result_e    res_o
);
  localparam logic [CW-1:0] RES_C = CW'(NRR);
  localparam logic [AW-1:0] OLD_C = AW'(NRR);

  logic open_pool, reserved_ok;
  assign open_pool   = free_cnt_i > RES_C;
  assign reserved_ok = (free_cnt_i != '0) && (age_i < OLD_C);

  always_comb begin
    if (!req_i)                      res_o = WB_IDLE;
    else if (open_pool || reserved_ok) res_o = WB_GRANT;
    else                             res_o = WB_REEXEC;
  end
endmodule

// File: rtl/vp_renamer.sv
module vp_renamer
  import rnm_pkg::*;
#(
  parameter int NLOG  = 32,
  parameter int NVP   = 64,
  parameter int NPHYS = 48,
  parameter int NRR   = 4,
  parameter int AW    = 6,
  localparam int LW  = $clog2(NLOG),
  localparam int VW  = $clog2(NVP),
  localparam int PW  = $clog2(NPHYS),
  localparam int VCW = $clog2(NVP + 1),
  localparam int PCW = $clog2(NPHYS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ren_valid_i,
  input  logic [LW-1:0] ren_dst_i,
  input  logic [LW-1:0] ren_src1_i,
  input  logic [LW-1:0] ren_src2_i,
  output logic          rn_valid_o,
  output logic          rn_stall_o,
  output logic [VW-1:0] rn_src1_vp_o,
  output logic          rn_src1_bound_o,
  output logic [VW-1:0] rn_src2_vp_o,
  output logic          rn_src2_bound_o,
  output logic [VW-1:0] rn_dst_vp_o,
  output logic [VW-1:0] rn_prev_vp_o,
  input  logic          wb_valid_i,
  input  logic [VW-1:0] wb_vp_i,
  input  logic [AW-1:0] wb_age_i,
  output logic          wb_done_o,
  output logic          wb_reexec_o,
  output logic [PW-1:0] wb_preg_o,
  input  logic          cm_valid_i,
  input  logic [VW-1:0] cm_prev_vp_i
);
  logic [VW-1:0] gmt   [NLOG];
  logic          pmt_v [NVP];
  logic [PW-1:0] pmt_p [NVP];

  logic [VW-1:0]  vp_head;
  logic [VCW-1:0] vp_cnt;
  logic [PW-1:0]  ph_head;
  logic [PCW-1:0] ph_cnt;
  logic           ren_go, wb_go, ph_push;
  wb_result_e     wb_res;

  assign ren_go  = ren_valid_i && (vp_cnt != '0);
  assign wb_go   = (wb_res == WB_GRANT);
  assign ph_push = cm_valid_i && pmt_v[cm_prev_vp_i];

  rnm_free_fifo #(.DEPTH(NVP), .W(VW), .INIT_BASE(NLOG), .INIT_COUNT(NVP - NLOG))
    vp_pool_i (.clk(clk), .rst(rst), .push_i(cm_valid_i), .push_data_i(cm_prev_vp_i),
               .pop_i(ren_go), .head_o(vp_head), .count_o(vp_cnt));

  rnm_free_fifo #(.DEPTH(NPHYS), .W(PW), .INIT_BASE(NLOG), .INIT_COUNT(NPHYS - NLOG))
    ph_pool_i (.clk(clk), .rst(rst), .push_i(ph_push), .push_data_i(pmt_p[cm_prev_vp_i]),
               .pop_i(wb_go), .head_o(ph_head), .count_o(ph_cnt));

  rnm_wb_alloc #(.NRR(NRR), .CW(PCW), .AW(AW))
    alloc_i (.req_i(wb_valid_i), .free_cnt_i(ph_cnt), .age_i(wb_age_i), .res_o(wb_res));

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NLOG; i++) gmt[i] <= VW'(i);
      for (int i = 0; i < NVP; i++) begin
        pmt_v[i] <= (i < NLOG);
        pmt_p[i] <= (i < NLOG) ? PW'(i) : '0;
      end
      rn_valid_o <= 1'b0; rn_stall_o <= 1'b0;
      rn_src1_vp_o <= '0; rn_src1_bound_o <= 1'b0;
      rn_src2_vp_o <= '0; rn_src2_bound_o <= 1'b0;
      rn_dst_vp_o <= '0;  rn_prev_vp_o <= '0;
      wb_done_o <= 1'b0;  wb_reexec_o <= 1'b0; wb_preg_o <= '0;
    end else begin
      rn_valid_o      <= ren_go;
      rn_stall_o      <= ren_valid_i && !ren_go;
      rn_src1_vp_o    <= gmt[ren_src1_i];
      rn_src1_bound_o <= pmt_v[gmt[ren_src1_i]];
      rn_src2_vp_o    <= gmt[ren_src2_i];
      rn_src2_bound_o <= pmt_v[gmt[ren_src2_i]];
      rn_dst_vp_o     <= ren_go ? vp_head : '0;
      rn_prev_vp_o    <= gmt[ren_dst_i];
      wb_done_o       <= wb_go;
      wb_reexec_o     <= (wb_res == WB_REEXEC);
      wb_preg_o       <= wb_go ? ph_head : '0;
      if (cm_valid_i) pmt_v[cm_prev_vp_i] <= 1'b0;
      if (ren_go) begin
        gmt[ren_dst_i] <= vp_head;
        pmt_v[vp_head] <= 1'b0;
      end
      if (wb_go) begin
        pmt_v[wb_vp_i] <= 1'b1;
        pmt_p[wb_vp_i] <= ph_head;
      end
    end
  end

  AST_WB_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(wb_done_o && wb_reexec_o)); // R10
  AST_REN_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(rn_valid_o && rn_stall_o)); // R10
  AST_RESERVE_GUARD: assert property (@(posedge clk) disable iff (rst)
    wb_done_o |-> ($past(ph_cnt) > PCW'(NRR) || $past(wb_age_i) < AW'(NRR))); // R6
  AST_REEXEC_CAUSE: assert property (@(posedge clk) disable iff (rst)
    wb_reexec_o |-> ($past(ph_cnt) <= PCW'(NRR))); // R7
  AST_STALL_CAUSE: assert property (@(posedge clk) disable iff (rst)
    rn_stall_o |-> ($past(vp_cnt) == '0)); // R9
endmodule

// File: tb/vp_renamer_tb.sv
`timescale 1ns/1ps
module vp_renamer_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ren_valid_i = 0, wb_valid_i = 0, cm_valid_i = 0;
  logic [4:0] ren_dst_i = 0, ren_src1_i = 0, ren_src2_i = 0;
  logic [5:0] wb_vp_i = 0, wb_age_i = 0, cm_prev_vp_i = 0;
  logic rn_valid_o, rn_stall_o, rn_src1_bound_o, rn_src2_bound_o;
  logic [5:0] rn_src1_vp_o, rn_src2_vp_o, rn_dst_vp_o, rn_prev_vp_o;
  logic wb_done_o, wb_reexec_o;
  logic [5:0] wb_preg_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  vp_renamer dut_i (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_rename(input int dst, input int s1, input int s2);
    @(negedge clk);
    ren_valid_i = 1; ren_dst_i = 5'(dst); ren_src1_i = 5'(s1); ren_src2_i = 5'(s2);
    @(negedge clk);
    ren_valid_i = 0;
  endtask

  task automatic do_wb(input int vp, input int age);
    @(negedge clk);
    wb_valid_i = 1; wb_vp_i = 6'(vp); wb_age_i = 6'(age);
    @(negedge clk);
    wb_valid_i = 0;
  endtask

  task automatic do_commit(input int vp);
    @(negedge clk);
    cm_valid_i = 1; cm_prev_vp_i = 6'(vp);
    @(negedge clk);
    cm_valid_i = 0;
  endtask

  task automatic test_reset();
    chk("R1 rn_valid after reset", rn_valid_o, 0);
    chk("R1 wb_done after reset", wb_done_o, 0);
    do_rename(7, 5, 6);
    chk("R1 src1 tag", rn_src1_vp_o, 5);
    chk("R1 src1 bound", rn_src1_bound_o, 1);
    chk("R1 src2 tag", rn_src2_vp_o, 6);
    chk("R2 valid", rn_valid_o, 1);
    chk("R2 dst tag first free", rn_dst_vp_o, 32);
    chk("R2 prev tag", rn_prev_vp_o, 7);
  endtask

  task automatic test_self_source();
    do_rename(7, 7, 7);
    chk("R3 src1 old tag", rn_src1_vp_o, 32);
    chk("R4 new tag unbound", rn_src1_bound_o, 0);
    chk("R3 src2 old tag", rn_src2_vp_o, 32);
    chk("R2 dst tag second", rn_dst_vp_o, 33);
    chk("R2 prev tag chain", rn_prev_vp_o, 32);
  endtask

  task automatic test_bind();
    do_wb(33, 0);
    chk("R5 grant", wb_done_o, 1);
    chk("R5 preg first free", wb_preg_o, 32);
    chk("R10 no reexec with grant", wb_reexec_o, 0);
    do_rename(9, 7, 1);
    chk("R4 bound after wb", rn_src1_bound_o, 1);
    chk("R4 tag", rn_src1_vp_o, 33);
  endtask

  task automatic test_reserve();
    for (int i = 0; i < 11; i++) begin
      do_wb(40 + i, 0);
      chk("R5 preg order", wb_preg_o, 33 + i);
    end
    do_wb(51, 5);
    chk("R6 young refused", wb_reexec_o, 1);
    chk("R6 young not granted", wb_done_o, 0);
    chk("R6 preg zero", wb_preg_o, 0);
    do_wb(51, 2);
    chk("R6 old granted", wb_done_o, 1);
    chk("R6 reserved preg", wb_preg_o, 44);
    for (int i = 0; i < 3; i++) begin
      do_wb(52 + i, 0);
      chk("R6 drain reserve", wb_preg_o, 45 + i);
    end
    do_wb(55, 0);
    chk("R7 empty oldest reexec", wb_reexec_o, 1);
    chk("R7 empty no grant", wb_done_o, 0);
  endtask

  task automatic test_release_and_stall();
    do_commit(7);
    do_wb(56, 0);
    chk("R8 released preg reused", wb_preg_o, 7);
    for (int i = 0; i < 29; i++) begin
      do_rename(10, 0, 0);
      chk("R2 tag order", rn_dst_vp_o, 35 + i);
    end
    do_rename(10, 0, 0);
    chk("R8 released tag at tail", rn_dst_vp_o, 7);
    do_rename(3, 0, 0);
    chk("R9 stall", rn_stall_o, 1);
    chk("R9 not valid", rn_valid_o, 0);
    do_commit(20);
    do_rename(4, 3, 3);
    chk("R9 map unchanged tag", rn_src1_vp_o, 3);
    chk("R9 map unchanged bound", rn_src1_bound_o, 1);
    chk("R8 commit tag reused", rn_dst_vp_o, 20);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;
    test_reset();
    test_self_source();
    test_bind();
    test_reserve();
    test_release_and_stall();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule